// File: doc/BRIEF.md
# Serial Transceiver with Flow Control

A full-duplex asynchronous serial port. It sends and receives 8-bit characters framed by one start bit and one stop bit, with an optional parity bit. A 16x oversampling tick comes from a programmable clock divider. Two registers are exposed on a simple word bus: a configuration register and a data register. The configuration register holds the enable, parity and flow-control settings and the divider, and it reports the current clear-to-send level. A write to the data register queues one byte for transmission. A read from the data register takes the oldest received byte together with its own error flags.

Received characters go into a two-slot buffer. When request-to-send flow control is on, the ready-to-receive line (`rts_n`, active low) is withdrawn while both slots are occupied. When clear-to-send flow control is on, the transmitter opens a new frame only while the `cts_n` input (active low) is asserted. That input is looked at only when a frame is about to start. There are two interrupt outputs. The receive interrupt is raised by every arriving character. The transmit interrupt is a one-cycle pulse at the end of a frame when nothing more is queued.

Top module: `uart_fc_top`

## Requirements
- R1: A transmitted frame is a 0 start bit, 8 data bits LSB first, an optional parity bit, then a 1 stop bit. Each bit lasts 16 x DIV clock cycles, where DIV is configuration bits 31:16. `uart_txd` idles at 1.
- R2: Configuration bit 1 enables parity and bit 2 selects odd parity. The parity bit follows the data bits. Even parity sends the XOR of the data bits, and odd parity sends its inverse.
- R3: Data register bit 8 flags a parity mismatch on a received character. The flag belongs to each character and is freshly computed for every new one.
- R4: Data register bit 9 flags a received stop bit that was 0. It is freshly computed for every character.
- R5: Up to two unread received characters are held and read back in arrival order. Data register bit 31 shows that a character is available, and bits 7:0 hold the character. Reading the data register removes the character. An empty read returns 0.
- R6: With configuration bit 3 set, `rts_n` is 1 while both receive slots are full and 0 otherwise. With bit 3 clear, `rts_n` is 0.
- R7: With configuration bit 4 set, a queued byte starts its frame only while `cts_n` is 0. A change on `cts_n` after the frame has started does not alter that frame.
- R8: Configuration read bit 8 is 1 when `cts_n` is low, two clock cycles after a change. Configuration read bit 9 is 1 while a byte is queued or being sent.
- R9: `irq_rx` becomes 1 on every received character, including when a slot is already occupied. It returns to 0 on a data register read or while the block is disabled.
- R10: `irq_tx` is a one-cycle pulse when a stop bit completes and no further byte is queued.
- R11: After reset, `uart_txd` is 1, `rts_n` is 0, both interrupts are 0, the configuration reads back as 0 apart from the clear-to-send level, and no character is available.
- R12: Clearing configuration bit 0 (enable) discards buffered characters and any queued byte, and holds `uart_txd` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (a data read removes a character) |
| bus_addr | input | 1 | 0 selects configuration, 1 selects data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| uart_rxd | input | 1 | Serial receive line |
| uart_txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Ready to receive, active low |
| irq_rx | output | 1 | Receive interrupt (level) |
| irq_tx | output | 1 | Transmit-done interrupt (pulse) |

## Verification
With DIV set to 2, one bit lasts 32 cycles. The bench therefore samples the transmit line 16 cycles after the falling start edge and every 32 cycles after that, which keeps each sample near mid-bit despite the up-to-two-cycle jitter of the tick phase. A received character lands in the buffer, and raises `irq_rx`, at the middle of its stop bit. The bench checks it only after it has driven the whole stop bit and a few idle cycles. The clear-to-send level passes two synchronizer stages, so it is read three cycles after `cts_n` moves. Buffer levels, and therefore `rts_n`, change on the edge of the read strobe, so they are checked on the following falling edge.

// File: rtl/uart_fc_pkg.sv
// Shared constants and types of the serial transceiver.
// Assumes 8-bit characters and a 16x oversampling tick.
package uart_fc_pkg;
    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int DIV_W  = 16;

    // configuration register bit positions
    localparam int CFG_EN     = 0;
    localparam int CFG_PAR    = 1;
    localparam int CFG_ODD    = 2;
    localparam int CFG_RTS    = 3;
    localparam int CFG_CTS    = 4;
    localparam int CFG_DIV_LO = 16;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_char_t;
endpackage

// File: rtl/uart_fc_baud.sv
// Oversampling tick generator: one-cycle tick every div cycles.
// Assumes div of 0 or 1 means a tick on every cycle; held idle while run is low.
module uart_fc_baud #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt;

    // count cycles and emit a tick when the divider period ends
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (div == '0 || cnt >= div - DW'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DW'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fc_tx.sv
// Transmitter: one-byte holding register plus a frame shifter.
// The clear-to-send condition is tested only in idle, so a frame that has
// started always completes. Assumes tick is a 16x oversampling strobe.
module uart_fc_tx
    import uart_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              cts_fc,
    input  logic              cts_ok,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              busy,
    output logic              active,
    output logic              done_pulse
);
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    tx_st_t            st;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] hold;
    logic              hold_full;
    logic              par;
    logic              last_tick;

    assign last_tick = tick && (tcnt == TW'(OVS - 1));
    assign active    = (st != T_IDLE);
    assign busy      = hold_full || active;

    // holding register, frame sequencing and line drive
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st         <= T_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            sh         <= '0;
            hold       <= '0;
            hold_full  <= 1'b0;
            par        <= 1'b0;
            txd        <= 1'b1;
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            if (load && !hold_full) begin
                hold_full <= 1'b1;
                hold      <= load_data;
            end
            if (st != T_IDLE && tick)
                tcnt <= last_tick ? '0 : tcnt + TW'(1);
            case (st)
                T_IDLE: begin
                    txd <= 1'b1;
                    if (hold_full && (!cts_fc || cts_ok)) begin
                        sh        <= hold;
                        par       <= (^hold) ^ par_odd;
                        hold_full <= 1'b0;
                        txd       <= 1'b0;
                        tcnt      <= '0;
                        st        <= T_START;
                    end
                end
                T_START: if (last_tick) begin
                    txd  <= sh[0];
                    bidx <= '0;
                    st   <= T_DATA;
                end
                T_DATA: if (last_tick) begin
                    if (bidx == BW'(DATA_W - 1)) begin
                        st  <= par_en ? T_PAR : T_STOP;
                        txd <= par_en ? par : 1'b1;
                    end else begin
                        sh   <= sh >> 1;
                        txd  <= sh[1];
                        bidx <= bidx + BW'(1);
                    end
                end
                T_PAR: if (last_tick) begin
                    txd <= 1'b1;
                    st  <= T_STOP;
                end
                T_STOP: if (last_tick) begin
                    st         <= T_IDLE;
                    done_pulse <= !hold_full;
                end
                default: st <= T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fc_rx.sv
// Receiver: finds a start edge, confirms it at mid-bit and then samples every
// bit at its centre. Delivers one character per frame with parity and stop
// flags. After a 0 stop bit it waits for the line to go high before re-arming.
// Assumes rxd_s is already synchronized to clk.
module uart_fc_rx
    import uart_fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd_s,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              push_perr,
    output logic              push_ferr
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_st_t;
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W);

    rx_st_t            st;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] sh;
    logic              par_bit;
    logic              mid_start;
    logic              mid_bit;

    assign mid_start = tick && (tcnt == TW'(OVS / 2 - 1));
    assign mid_bit   = tick && (tcnt == TW'(OVS - 1));

    // frame detection, centre sampling and character delivery
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st        <= R_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            sh        <= '0;
            par_bit   <= 1'b0;
            push      <= 1'b0;
            push_data <= '0;
            push_perr <= 1'b0;
            push_ferr <= 1'b0;
        end else begin
            push <= 1'b0;
            case (st)
                R_IDLE: if (!rxd_s) begin
                    tcnt <= '0;
                    st   <= R_START;
                end
                R_START: if (mid_start) begin
                    tcnt <= '0;
                    bidx <= '0;
                    st   <= rxd_s ? R_IDLE : R_DATA;
                end else if (tick) begin
                    tcnt <= tcnt + TW'(1);
                end
                R_DATA: if (mid_bit) begin
                    tcnt <= '0;
                    sh   <= {rxd_s, sh[DATA_W-1:1]};
                    if (bidx == BW'(DATA_W - 1))
                        st <= par_en ? R_PAR : R_STOP;
                    else
                        bidx <= bidx + BW'(1);
                end else if (tick) begin
                    tcnt <= tcnt + TW'(1);
                end
                R_PAR: if (mid_bit) begin
                    tcnt    <= '0;
                    par_bit <= rxd_s;
                    st      <= R_STOP;
                end else if (tick) begin
                    tcnt <= tcnt + TW'(1);
                end
                R_STOP: if (mid_bit) begin
                    tcnt      <= '0;
                    push      <= 1'b1;
                    push_data <= sh;
                    push_perr <= par_en && (par_bit != ((^sh) ^ par_odd));
                    push_ferr <= !rxd_s;
                    st        <= rxd_s ? R_IDLE : R_HOLD;
                end else if (tick) begin
                    tcnt <= tcnt + TW'(1);
                end
                R_HOLD: if (rxd_s) st <= R_IDLE;
                default: st <= R_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fc_rxq.sv
// Small first-in first-out buffer for received characters.
// A push into a full buffer is dropped unless a pop frees a slot that cycle.
// flush empties it synchronously. dout is the oldest entry (combinational).
module uart_fc_rxq #(
    parameter int DEPTH = 2,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] lvl;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (lvl == '0);
    assign full    = (lvl == LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   lvl <= lvl + LW'(1);
                2'b01:   lvl <= lvl - LW'(1);
                default: lvl <= lvl;
            endcase
        end
    end
endmodule

// File: rtl/uart_fc_top.sv
// Serial transceiver top: register decode, input synchronizers, flow-control
// lines and interrupts around the tick generator, transmitter, receiver and
// receive buffer. Assumes a single-cycle read/write strobe per access.
module uart_fc_top
    import uart_fc_pkg::*;
#(
    parameter int RXQ_DEPTH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        uart_rxd,
    output logic        uart_txd,
    input  logic        cts_n,
    output logic        rts_n,
    output logic        irq_rx,
    output logic        irq_tx
);
    localparam int CW = $bits(rx_char_t);

    logic             ctrl_en, par_en, par_odd, rts_fc, cts_fc;
    logic [DIV_W-1:0] ctrl_div;
    logic             cts_s1, cts_s2, rxd_s1, rxd_s2, cts_ok;
    logic             tick, tx_busy, tx_active;
    logic             rx_push, rx_perr, rx_ferr, rx_full, rx_empty, rx_pop;
    logic [DATA_W-1:0] rx_data;
    rx_char_t         rx_in, rx_head;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[CFG_DIV_LO-1:CFG_CTS+1];

    // configuration register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ctrl_en, par_en, par_odd, rts_fc, cts_fc} <= '0;
            ctrl_div <= '0;
        end else if (bus_we && !bus_addr) begin
            ctrl_en  <= bus_wdata[CFG_EN];
            par_en   <= bus_wdata[CFG_PAR];
            par_odd  <= bus_wdata[CFG_ODD];
            rts_fc   <= bus_wdata[CFG_RTS];
            cts_fc   <= bus_wdata[CFG_CTS];
            ctrl_div <= bus_wdata[CFG_DIV_LO +: DIV_W];
        end
    end

    // two-stage synchronizers for the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cts_s1, cts_s2, rxd_s1, rxd_s2} <= 4'b1111;
        end else begin
            cts_s1 <= cts_n;
            cts_s2 <= cts_s1;
            rxd_s1 <= uart_rxd;
            rxd_s2 <= rxd_s1;
        end
    end
    assign cts_ok = !cts_s2;

    uart_fc_baud #(.DW(DIV_W)) i_baud (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en), .div(ctrl_div), .tick(tick)
    );

    uart_fc_tx i_tx (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick),
        .par_en(par_en), .par_odd(par_odd), .cts_fc(cts_fc), .cts_ok(cts_ok),
        .load(bus_we && bus_addr), .load_data(bus_wdata[DATA_W-1:0]),
        .txd(uart_txd), .busy(tx_busy), .active(tx_active), .done_pulse(irq_tx)
    );

    uart_fc_rx i_rx (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .tick(tick),
        .par_en(par_en), .par_odd(par_odd), .rxd_s(rxd_s2),
        .push(rx_push), .push_data(rx_data), .push_perr(rx_perr), .push_ferr(rx_ferr)
    );

    assign rx_in  = '{ferr: rx_ferr, perr: rx_perr, data: rx_data};
    assign rx_pop = bus_re && bus_addr;

    uart_fc_rxq #(.DEPTH(RXQ_DEPTH), .W(CW)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!ctrl_en),
        .push(rx_push), .din(rx_in), .pop(rx_pop),
        .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    assign rts_n = rts_fc && rx_full;

    // receive interrupt: set on each arrival, cleared by a data read or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) irq_rx <= 1'b0;
        else if (rx_push)       irq_rx <= 1'b1;
        else if (rx_pop)        irq_rx <= 1'b0;
    end

    // read data multiplexer
    always_comb begin
        if (!bus_addr)
            bus_rdata = {ctrl_div, 6'b0, tx_busy, cts_ok, 3'b0,
                         cts_fc, rts_fc, par_odd, par_en, ctrl_en};
        else if (rx_empty)
            bus_rdata = '0;
        else
            bus_rdata = {1'b1, 21'b0, rx_head.ferr, rx_head.perr, rx_head.data};
    end
endmodule

// File: rtl/uart_fc_chk.sv
// Assertion checker for uart_fc_top, attached by bind below.
module uart_fc_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_re,
    input logic bus_addr,
    input logic rx_push,
    input logic irq_rx,
    input logic irq_tx,
    input logic ctrl_en,
    input logic cts_fc,
    input logic cts_ok,
    input logic tx_active,
    input logic uart_txd,
    input logic rts_n,
    input logic rts_fc,
    input logic rx_full,
    input logic rx_empty
);
    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> uart_txd);
    // R10
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx);
    // R9
    rx_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && ctrl_en) |=> irq_rx);
    // R9
    rx_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr && !rx_push) |=> !irq_rx);
    // R7
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_fc && !cts_ok && !tx_active) |=> !tx_active);
    // R6
    rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $stable(rts_fc)) |-> $past(rx_push));
    // R5
    buf_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));
endmodule

bind uart_fc_top uart_fc_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_addr(bus_addr),
    .rx_push(rx_push), .irq_rx(irq_rx), .irq_tx(irq_tx), .ctrl_en(ctrl_en),
    .cts_fc(cts_fc), .cts_ok(cts_ok), .tx_active(tx_active), .uart_txd(uart_txd),
    .rts_n(rts_n), .rts_fc(rts_fc), .rx_full(rx_full), .rx_empty(rx_empty)
);

// File: tb/test_uart_fc_top.sv
// Directed bench for uart_fc_top: one task per scenario, DIV = 2 (32 cycles/bit).
module test_uart_fc_top;
    localparam int CLK_P = 10;
    localparam int BIT_C = 32;
    localparam int WD    = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        uart_rxd = 1'b1;
    logic        uart_txd;
    logic        cts_n = 1'b0;
    logic        rts_n, irq_rx, irq_tx;

    int n_chk = 0, n_fail = 0, tx_irq_cnt = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_fc_top i_uart_fc_top (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uart_rxd(uart_rxd), .uart_txd(uart_txd), .cts_n(cts_n), .rts_n(rts_n),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    always @(posedge clk) if (irq_tx === 1'b1) tx_irq_cnt <= tx_irq_cnt + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg(bit pe, bit po, bit rts, bit cts, bit en = 1'b1);
        return {16'd2, 11'b0, cts, rts, po, pe, en};
    endfunction

    function automatic logic [31:0] rxword(logic [7:0] d, bit pe, bit fe);
        return {1'b1, 21'b0, fe, pe, d};
    endfunction

    task automatic bus_wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // drive one frame on uart_rxd; pmode 0 none, 1 correct even, 2 wrong even
    task automatic send_rx(input logic [7:0] d, input int pmode, input bit stopb);
        logic [10:0] bits;
        int n;
        bits = {1'b1, 1'b0, d, 1'b0};
        n = 10;
        if (pmode != 0) begin
            bits = {stopb, (pmode == 1) ? ^d : ~^d, d, 1'b0};
            n = 11;
        end else begin
            bits[9] = stopb;
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            uart_rxd = bits[i];
            repeat (BIT_C - 1) @(negedge clk);
        end
        @(negedge clk);
        uart_rxd = 1'b1;
        repeat (BIT_C) @(negedge clk);
    endtask

    // capture one frame from uart_txd, sampling at mid-bit
    task automatic grab_tx(input bit par, output logic [7:0] d, output logic pb,
                           output logic sb, output bit seen);
        int t = 0;
        seen = 0; d = '0; pb = 1'b0; sb = 1'b0;
        while (uart_txd !== 1'b0 && t < 3000) begin
            @(negedge clk); t++;
        end
        if (uart_txd !== 1'b0) return;
        repeat (BIT_C/2) @(negedge clk);
        seen = (uart_txd === 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_C) @(negedge clk);
            d[i] = uart_txd;
        end
        if (par) begin
            repeat (BIT_C) @(negedge clk);
            pb = uart_txd;
        end
        repeat (BIT_C) @(negedge clk);
        sb = uart_txd;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R11 txd idle", uart_txd, 1);
        chk("R11 rts_n", rts_n, 0);
        chk("R11 irq_rx", irq_rx, 0);
        chk("R11 irq_tx", irq_tx, 0);
        bus_rd(0, v);
        chk("R11 cfg reset", v, 32'h0000_0100);
        bus_rd(1, v);
        chk("R11 no data", v, 0);
    endtask

    task automatic t_tx_plain;
        logic [7:0] d; logic pb, sb; bit seen; int c0;
        bus_wr(0, cfg(0, 0, 0, 0));
        c0 = tx_irq_cnt;
        bus_wr(1, 32'hA5);
        grab_tx(0, d, pb, sb, seen);
        chk("R1 start bit", seen, 1);
        chk("R1 data A5", d, 8'hA5);
        chk("R1 stop bit", sb, 1);
        repeat (BIT_C + 4) @(negedge clk);
        chk("R10 one tx pulse", tx_irq_cnt - c0, 1);
    endtask

    task automatic t_tx_parity;
        logic [7:0] d; logic pb, sb; bit seen;
        bus_wr(0, cfg(1, 0, 0, 0));
        bus_wr(1, 32'h07);
        grab_tx(1, d, pb, sb, seen);
        chk("R2 even data", d, 8'h07);
        chk("R2 even parity bit", pb, 1);
        chk("R2 stop after parity", sb, 1);
        repeat (BIT_C) @(negedge clk);
        bus_wr(0, cfg(1, 1, 0, 0));
        bus_wr(1, 32'h07);
        grab_tx(1, d, pb, sb, seen);
        chk("R2 odd parity bit", pb, 0);
        repeat (BIT_C) @(negedge clk);
    endtask

    task automatic t_rx_basic;
        logic [31:0] v;
        bus_wr(0, cfg(0, 0, 0, 0));
        send_rx(8'h5A, 0, 1);
        chk("R9 irq on arrival", irq_rx, 1);
        bus_rd(1, v);
        chk("R5 read char", v, rxword(8'h5A, 0, 0));
        chk("R9 irq cleared by read", irq_rx, 0);
        bus_rd(1, v);
        chk("R5 empty read", v, 0);
    endtask

    task automatic t_rx_errors;
        logic [31:0] v;
        bus_wr(0, cfg(1, 0, 0, 0));
        send_rx(8'h33, 2, 1);
        bus_rd(1, v);
        chk("R3 parity error set", v, rxword(8'h33, 1, 0));
        send_rx(8'h33, 1, 1);
        bus_rd(1, v);
        chk("R3 parity flag refreshed", v, rxword(8'h33, 0, 0));
        bus_wr(0, cfg(0, 0, 0, 0));
        send_rx(8'h44, 0, 0);
        bus_rd(1, v);
        chk("R4 frame error set", v, rxword(8'h44, 0, 1));
        send_rx(8'hC3, 0, 1);
        bus_rd(1, v);
        chk("R4 frame flag refreshed", v, rxword(8'hC3, 0, 0));
    endtask

    task automatic t_rx_buffer;
        logic [31:0] v;
        bus_wr(0, cfg(0, 0, 1, 0));
        send_rx(8'h11, 0, 1);
        chk("R6 rts with one slot", rts_n, 0);
        send_rx(8'h22, 0, 1);
        chk("R6 rts withdrawn when full", rts_n, 1);
        bus_rd(1, v);
        chk("R5 oldest first", v, rxword(8'h11, 0, 0));
        chk("R6 rts back after read", rts_n, 0);
        chk("R9 cleared with char left", irq_rx, 0);
        send_rx(8'h33, 0, 1);
        chk("R9 irq with slot occupied", irq_rx, 1);
        bus_rd(1, v);
        chk("R5 second char", v, rxword(8'h22, 0, 0));
        bus_rd(1, v);
        chk("R5 third char", v, rxword(8'h33, 0, 0));
        bus_wr(0, cfg(0, 0, 0, 0));
        send_rx(8'h01, 0, 1);
        send_rx(8'h02, 0, 1);
        chk("R6 rts off when disabled", rts_n, 0);
        bus_rd(1, v);
        bus_rd(1, v);
    endtask

    task automatic t_cts;
        logic [31:0] v; logic [7:0] d; logic pb, sb; bit seen; bit low_seen = 0;
        cts_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(0, v);
        chk("R8 cts level low", v[8], 0);
        bus_wr(0, cfg(0, 0, 0, 1));
        bus_wr(1, 32'h96);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (uart_txd !== 1'b1) low_seen = 1;
        end
        chk("R7 held while cts off", low_seen, 0);
        bus_rd(0, v);
        chk("R8 busy while queued", v[9], 1);
        fork
            begin
                @(negedge clk);
                cts_n = 1'b0;
                grab_tx(0, d, pb, sb, seen);
            end
            begin
                repeat (80) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        chk("R7 frame unaffected by cts", d, 8'h96);
        chk("R7 stop intact", sb, 1);
        cts_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_rd(0, v);
        chk("R8 cts level high", v[8], 1);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        bus_wr(0, cfg(0, 0, 0, 0));
        send_rx(8'h77, 0, 1);
        chk("R9 irq before disable", irq_rx, 1);
        bus_wr(0, cfg(0, 0, 0, 0, 0));
        @(negedge clk);
        chk("R9 irq cleared by disable", irq_rx, 0);
        bus_wr(1, 32'h55);
        repeat (20) @(negedge clk);
        chk("R12 txd held high", uart_txd, 1);
        bus_rd(1, v);
        chk("R12 buffer flushed", v, 0);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_tx_plain();
        t_tx_parity();
        t_rx_basic();
        t_rx_errors();
        t_rx_buffer();
        t_cts();
        t_disable();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule